// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Channel

This block is one device-to-host DMA channel that follows a chain of fixed-size descriptors kept in host memory. Software supplies the byte address of the first descriptor and raises the enable input. The channel then reads each descriptor through a 32-bit memory request port and decodes its flags, byte count and buffer address. It takes the described number of 32-bit words from a valid/ready device stream and writes them to consecutive host-memory words. Dropping enable halts the channel at once.

When the descriptor flagged as last has been completed, the channel emits a one-cycle done pulse and goes idle. A descriptor whose valid flag is clear stops the chain and raises an error. A row tracker pulses at every line boundary in the incoming data, using a line length that is captured at start.

Top module: `sgdma_channel`

## Requirements
- R1: A descriptor occupies 8 bytes. The word at the descriptor pointer holds the flags in bits 7:0 (bit 0 valid, bit 1 last, bit 5 transfer), reserved bits 15:8 and the byte count in bits 31:16. The word at pointer+4 holds the buffer byte address. The following descriptor sits at pointer+8.
- R2: A rising edge of `enable_i` while idle starts the chain at `list_addr_i`. Each descriptor is fetched as two reads: first the pointer, then pointer+4.
- R3: An entry with valid and transfer set moves count/4 words, ignoring the two low bits of the count. Words are written in stream order to consecutive word addresses starting at the buffer address. A stream word is taken (`src_ready_o` high) only in the cycle its memory write is granted.
- R4: After the last entry finishes, `done_o` is high for exactly one cycle, `busy_o` is low from the same cycle, and no further descriptor is fetched.
- R5: An entry whose count is below 4 or whose transfer flag is clear issues no memory write. The channel goes on to the next descriptor, or finishes with done if that entry is last.
- R6: A fetched descriptor with its valid flag clear moves no data and does not raise done. `error_o` then stays high until `enable_i` is lowered.
- R7: While `enable_i` is low, `mem_req_o` and `src_ready_o` are low in the same cycle, and `busy_o` is low from the next cycle on.
- R8: A memory read request that is not granted is held with an unchanged address until it is granted.
- R9: `row_end_o` pulses each time the bytes written since start, or since the previous pulse, reach the row length sampled at start. A row length of 0 produces no pulses.
- R10: After reset the channel is idle: `busy_o`, `done_o`, `error_o`, `row_end_o`, `mem_req_o` and `src_ready_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run control: a rising edge starts the chain, low halts it |
| list_addr_i | input | ADDR_W | Byte address of the first descriptor |
| row_len_i | input | ROW_W | Line length in bytes, sampled at start (0 turns row tracking off) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write (1) or a read (0) |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| src_valid_i | input | 1 | Device stream word valid |
| src_data_i | input | DATA_W | Device stream word |
| src_ready_o | output | 1 | Device stream word taken |
| busy_o | output | 1 | Channel is not idle |
| done_o | output | 1 | One-cycle pulse when the chain completes |
| error_o | output | 1 | Invalid descriptor met, held until enable is low |
| row_end_o | output | 1 | One-cycle pulse at each row boundary |

## Verification
The bench builds the channel with the full 16-bit count field and a narrowed 8-bit row-length parameter, and keeps row tracking enabled. It sweeps single-entry lists from one to eight words, each length with and without random stalls on both the grant and the stream valid. Counts carrying junk in their two low bits exercise the word truncation. Further runs cover mixed chains with zero-count and non-transfer entries, a mid-chain invalid descriptor, a halt during a long transfer, and a sweep of row lengths whose expected pulse counts are computed by division.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   // Descriptor geometry; the flag positions are decoded by the channel.
   localparam int unsigned DESC_BYTES = 8;
   localparam int unsigned PTR_OFFSET = 4;
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned FLAG_VALID = 0;
   localparam int unsigned FLAG_LAST  = 1;
   localparam int unsigned FLAG_XFER  = 5;
   localparam int unsigned LEN_LSB    = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR_REQ,
      ST_HDR_WAIT,
      ST_PTR_REQ,
      ST_PTR_WAIT,
      ST_DECIDE,
      ST_MOVE,
      ST_FAULT
   } sg_state_e;
endpackage

// File: rtl/sgdma_hdr_decode.sv
module sgdma_hdr_decode
   import sgdma_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int WRD_W = CNT_W - 2
) (
   input  logic [31:0]      hdr_i,
   output logic             ok_o,
   output logic             xfer_o,
   output logic             tail_o,
   output logic [WRD_W-1:0] words_o
);
   generate
      if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt
         $error("sgdma_hdr_decode: CNT_W must lie in 3..16");
      end
   endgenerate

   assign ok_o    = hdr_i[FLAG_VALID];
   assign xfer_o  = hdr_i[FLAG_XFER];
   assign tail_o  = hdr_i[FLAG_LAST];
   // Count bits 1:0 are dropped: transfers are whole words.
   assign words_o = hdr_i[LEN_LSB+2 +: WRD_W];

   logic unused_hdr_bits;
   assign unused_hdr_bits = ^{hdr_i[LEN_LSB+1:6], hdr_i[4:2]};
endmodule

// File: rtl/sgdma_row_track.sv
module sgdma_row_track #(
   parameter int ROW_W  = 16,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             beat_i,
   input  logic [ROW_W-1:0] row_len_i,
   output logic             row_end_o
);
   generate
      if (ROW_W < 3) begin : g_bad_row
         $error("sgdma_row_track: ROW_W must be at least 3");
      end

      if (ENABLE) begin : g_on
         logic [ROW_W-1:0] len_q;
         logic [ROW_W:0]   acc_q;
         logic [ROW_W:0]   acc_nx;
         logic             hit;
         logic             end_q;

         assign acc_nx = acc_q + (ROW_W+1)'(4);
         assign hit    = (len_q != '0) && (acc_nx >= {1'b0, len_q});

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               len_q <= '0;
               acc_q <= '0;
               end_q <= 1'b0;
            end else if (clear_i) begin
               len_q <= row_len_i;
               acc_q <= '0;
               end_q <= 1'b0;
            end else begin
               end_q <= beat_i && hit;
               if (beat_i) acc_q <= hit ? '0 : acc_nx;
            end
         end

         assign row_end_o = end_q;

         // R9: the byte accumulator never reaches the captured row length
         p_row_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (len_q != '0) |-> (acc_q < {1'b0, len_q}));
      end else begin : g_off
         logic unused_row;
         assign unused_row = ^{clk_i, rst_ni, clear_i, beat_i, row_len_i};
         assign row_end_o  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
   import sgdma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int ROW_W     = 16,
   parameter bit ROW_TRACK = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [ADDR_W-1:0] list_addr_i,
   input  logic [ROW_W-1:0]  row_len_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              src_valid_i,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              src_ready_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o,
   output logic              row_end_o
);
   localparam int WRD_W = CNT_W - 2;
   localparam logic [ADDR_W-1:0] STEP_DESC = ADDR_W'(DESC_BYTES);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] OFS_PTR   = ADDR_W'(PTR_OFFSET);

   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("sgdma_channel: descriptor words require DATA_W == 32");
      end
      if (ADDR_W < 4 || ADDR_W > DATA_W) begin : g_bad_aw
         $error("sgdma_channel: ADDR_W must lie in 4..DATA_W");
      end
   endgenerate

   sg_state_e         st_q;
   logic              en_q;
   logic              done_q;
   logic [ADDR_W-1:0] dptr_q;
   logic [ADDR_W-1:0] bptr_q;
   logic [WRD_W-1:0]  left_q;
   logic [DATA_W-1:0] hdr_q;

   logic             hdr_ok;
   logic             hdr_xfer;
   logic             hdr_tail;
   logic [WRD_W-1:0] hdr_words;
   logic             beat;
   logic             start;

   sgdma_hdr_decode #(.CNT_W(CNT_W)) u_decode (
      .hdr_i   (hdr_q),
      .ok_o    (hdr_ok),
      .xfer_o  (hdr_xfer),
      .tail_o  (hdr_tail),
      .words_o (hdr_words)
   );

   // Request side: everything is gated by enable so a halt is immediate.
   always_comb begin
      mem_req_o  = 1'b0;
      mem_we_o   = (st_q == ST_MOVE);
      mem_addr_o = dptr_q;
      unique case (st_q)
         ST_PTR_REQ: mem_addr_o = dptr_q + OFS_PTR;
         ST_MOVE:    mem_addr_o = bptr_q;
         default:    mem_addr_o = dptr_q;
      endcase
      if (enable_i) begin
         unique case (st_q)
            ST_HDR_REQ, ST_PTR_REQ: mem_req_o = 1'b1;
            ST_MOVE:                mem_req_o = src_valid_i;
            default:                mem_req_o = 1'b0;
         endcase
      end
   end

   assign beat        = mem_req_o && mem_we_o && mem_gnt_i;
   assign src_ready_o = beat;
   assign mem_wdata_o = src_data_i;
   assign start       = enable_i && !en_q && (st_q == ST_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         en_q   <= 1'b0;
         done_q <= 1'b0;
         dptr_q <= '0;
         bptr_q <= '0;
         left_q <= '0;
         hdr_q  <= '0;
      end else begin
         en_q   <= enable_i;
         done_q <= 1'b0;
         if (!enable_i) begin
            st_q <= ST_IDLE;
         end else begin
            unique case (st_q)
               ST_IDLE: if (start) begin
                  dptr_q <= list_addr_i;
                  st_q   <= ST_HDR_REQ;
               end
               ST_HDR_REQ:  if (mem_gnt_i) st_q <= ST_HDR_WAIT;
               ST_HDR_WAIT: if (mem_rvalid_i) begin
                  hdr_q <= mem_rdata_i;
                  st_q  <= ST_PTR_REQ;
               end
               ST_PTR_REQ:  if (mem_gnt_i) st_q <= ST_PTR_WAIT;
               ST_PTR_WAIT: if (mem_rvalid_i) begin
                  bptr_q <= mem_rdata_i[ADDR_W-1:0];
                  st_q   <= ST_DECIDE;
               end
               ST_DECIDE: begin
                  if (!hdr_ok) begin
                     st_q <= ST_FAULT;
                  end else if (!hdr_xfer || hdr_words == '0) begin
                     if (hdr_tail) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end else begin
                        dptr_q <= dptr_q + STEP_DESC;
                        st_q   <= ST_HDR_REQ;
                     end
                  end else begin
                     left_q <= hdr_words;
                     st_q   <= ST_MOVE;
                  end
               end
               ST_MOVE: if (beat) begin
                  bptr_q <= bptr_q + STEP_WORD;
                  left_q <= left_q - WRD_W'(1);
                  if (left_q == WRD_W'(1)) begin
                     if (hdr_tail) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end else begin
                        dptr_q <= dptr_q + STEP_DESC;
                        st_q   <= ST_HDR_REQ;
                     end
                  end
               end
               ST_FAULT: st_q <= ST_FAULT;
               default:  st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy_o  = (st_q != ST_IDLE);
   assign error_o = (st_q == ST_FAULT);
   assign done_o  = done_q;

   sgdma_row_track #(.ROW_W(ROW_W), .ENABLE(ROW_TRACK)) u_rows (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (start),
      .beat_i    (beat),
      .row_len_i (row_len_i),
      .row_end_o (row_end_o)
   );

   // R4: done lasts a single cycle
   p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R4: done coincides with the channel being idle
   p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);
   // R8: an ungranted read keeps its request and address
   p_read_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !enable_i)
      (mem_req_o && !mem_we_o && !mem_gnt_i) |=> (mem_req_o && !mem_we_o && $stable(mem_addr_o)));
   // R6: a faulted channel is silent on both sides
   p_fault_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      error_o |-> (!mem_req_o && !src_ready_o));
   // R7: no traffic while halted
   p_halt_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |-> (!mem_req_o && !src_ready_o));
   // R3: a stream word is taken only with a granted write
   p_take_on_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_ready_o |-> (mem_req_o && mem_we_o && mem_gnt_i && src_valid_i));
endmodule

// File: tb/tb_sgdma_channel.sv
`timescale 1ns/1ps
module tb_sgdma_channel;
   localparam int ROW_W = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] list_addr = '0;
   logic [ROW_W-1:0] row_len = '0;
   logic        mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        src_valid, src_ready;
   logic [31:0] src_data;
   logic        busy, done, error, row_end;

   always #10 clk = ~clk;

   sgdma_channel #(.ADDR_W(32), .DATA_W(32), .CNT_W(16), .ROW_W(ROW_W), .ROW_TRACK(1'b1)) dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .list_addr_i(list_addr),
      .row_len_i(row_len), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
      .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .src_valid_i(src_valid),
      .src_data_i(src_data), .src_ready_o(src_ready), .busy_o(busy),
      .done_o(done), .error_o(error), .row_end_o(row_end)
   );

   // Host memory and device stream models
   logic [31:0] mem [0:255];
   logic        bd_we = 1'b0, bd_clr = 1'b0;
   logic [7:0]  bd_idx = '0;
   logic [31:0] bd_dat = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic        stall_en = 1'b0;
   int          src_idx = 0, wr_cnt = 0, rd_cnt = 0, done_cnt = 0, row_cnt = 0, hold_viol = 0;
   logic [31:0] first_rd = '0, second_rd = '0, prev_addr = '0;
   logic        prev_wait = 1'b0;
   int          nchk = 0, nfail = 0, cyc = 0;

   assign mem_gnt   = !(stall_en && lfsr[0]);
   assign src_valid = !(stall_en && lfsr[3]);
   assign src_data  = 32'hA500_0000 + 32'(src_idx);

   always @(posedge clk) begin
      lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_rvalid <= 1'b0;
      if (bd_clr) begin
         for (int i = 0; i < 256; i++) mem[i] <= 32'hEEEE_0000 + 32'(i);
         wr_cnt <= 0; rd_cnt <= 0; done_cnt <= 0; row_cnt <= 0;
      end else begin
         if (bd_we) mem[bd_idx] <= bd_dat;
         if (mem_req && mem_gnt) begin
            if (mem_we) begin
               mem[mem_addr[9:2]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= mem[mem_addr[9:2]];
               if (rd_cnt == 0) first_rd <= mem_addr;
               if (rd_cnt == 1) second_rd <= mem_addr;
               rd_cnt <= rd_cnt + 1;
            end
         end
         if (done) done_cnt <= done_cnt + 1;
         if (row_end) row_cnt <= row_cnt + 1;
      end
      if (src_valid && src_ready) src_idx <= src_idx + 1;
      if (prev_wait && enable && (!mem_req || mem_we || mem_addr != prev_addr))
         hold_viol <= hold_viol + 1;
      prev_wait <= mem_req && !mem_we && !mem_gnt;
      prev_addr <= mem_addr;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         nfail = nfail + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk = nchk + 1;
      if (act !== exp) begin
         nfail = nfail + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic poke(int idx, logic [31:0] dat);
      @(negedge clk); bd_we = 1'b1; bd_idx = 8'(idx); bd_dat = dat;
      @(negedge clk); bd_we = 1'b0;
   endtask

   task automatic clr();
      @(negedge clk); bd_clr = 1'b1;
      @(negedge clk); bd_clr = 1'b0;
   endtask

   task automatic desc(int addr, int cnt, logic [7:0] flg, int bufa);
      poke(addr >> 2, {16'(cnt), 8'h00, flg});
      poke((addr >> 2) + 1, 32'(bufa));
   endtask

   task automatic launch(int addr, int rl);
      @(negedge clk); enable = 1'b0; list_addr = 32'(addr); row_len = ROW_W'(rl);
      @(negedge clk); enable = 1'b1;
   endtask

   task automatic wait_end();
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (done_cnt != 0 || error) return;
      end
      chk("R4", "chain end timeout", 32'd0, 32'd1);
   endtask

   int base, w0;

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "busy after reset", 32'(busy), 32'd0);
      chk("R10", "done/error/row_end after reset", {29'd0, done, error, row_end}, 32'd0);
      chk("R10", "req/ready after reset", {30'd0, mem_req, src_ready}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "busy out of reset", 32'(busy), 32'd0);

      // Sweep: single last entry, 1..8 words, with and without stalls (R1 R2 R3 R4)
      for (int n = 1; n <= 8; n++) begin
         for (int s = 0; s < 2; s++) begin
            stall_en = 1'(s);
            clr();
            desc(0, n * 4 + (n % 4), 8'h23, 32'h200);
            base = src_idx;
            launch(0, 0);
            wait_end();
            repeat (4) @(negedge clk);
            chk("R4", "done pulses", 32'(done_cnt), 32'd1);
            chk("R4", "busy after done", 32'(busy), 32'd0);
            chk("R4", "descriptor reads", 32'(rd_cnt), 32'd2);
            chk("R2", "first fetch address", first_rd, 32'h0);
            chk("R1", "pointer fetch address", second_rd, 32'h4);
            chk("R3", "words written", 32'(wr_cnt), 32'(n));
            for (int j = 0; j < n; j++)
               chk("R3", "buffer word", mem[128 + j], 32'hA500_0000 + 32'(base + j));
            chk("R3", "word past buffer", mem[128 + n], 32'hEEEE_0000 + 32'(128 + n));
         end
      end
      chk("R8", "read hold violations", 32'(hold_viol), 32'd0);

      // Chain with zero-count and non-transfer entries (R1 R5)
      stall_en = 1'b1;
      clr();
      desc(32'h40, 8,  8'h21, 32'h300);
      desc(32'h48, 0,  8'h21, 32'h320);
      desc(32'h50, 8,  8'h01, 32'h340);
      desc(32'h58, 12, 8'h23, 32'h360);
      base = src_idx;
      launch(32'h40, 0);
      wait_end();
      repeat (4) @(negedge clk);
      chk("R1", "reads for four descriptors", 32'(rd_cnt), 32'd8);
      chk("R5", "writes in chain", 32'(wr_cnt), 32'd5);
      chk("R3", "entry0 word0", mem[192], 32'hA500_0000 + 32'(base));
      chk("R3", "entry0 word1", mem[193], 32'hA500_0000 + 32'(base + 1));
      chk("R5", "zero-count buffer untouched", mem[200], 32'hEEEE_0000 + 32'd200);
      chk("R5", "non-transfer buffer untouched", mem[208], 32'hEEEE_0000 + 32'd208);
      for (int j = 0; j < 3; j++)
         chk("R3", "entry3 word", mem[216 + j], 32'hA500_0000 + 32'(base + 2 + j));
      chk("R3", "past entry3", mem[219], 32'hEEEE_0000 + 32'd219);
      chk("R4", "chain done pulses", 32'(done_cnt), 32'd1);

      // Zero-count last entry finishes without writes (R5)
      clr();
      desc(32'h60, 0, 8'h23, 32'h300);
      launch(32'h60, 0);
      wait_end();
      repeat (4) @(negedge clk);
      chk("R5", "zero last done", 32'(done_cnt), 32'd1);
      chk("R5", "zero last writes", 32'(wr_cnt), 32'd0);
      chk("R5", "zero last buffer", mem[192], 32'hEEEE_0000 + 32'd192);

      // Invalid descriptor (R6)
      clr();
      desc(32'h80, 8, 8'h21, 32'h300);
      desc(32'h88, 8, 8'h20, 32'h320);
      launch(32'h80, 0);
      wait_end();
      repeat (4) @(negedge clk);
      chk("R6", "error raised", 32'(error), 32'd1);
      chk("R6", "no done on fault", 32'(done_cnt), 32'd0);
      chk("R6", "writes before fault", 32'(wr_cnt), 32'd2);
      chk("R6", "faulted buffer untouched", mem[200], 32'hEEEE_0000 + 32'd200);
      enable = 1'b0;
      @(negedge clk);
      chk("R6", "error cleared by enable low", 32'(error), 32'd0);
      chk("R7", "idle after enable low", 32'(busy), 32'd0);

      // Halt during a long transfer (R7)
      clr();
      desc(32'hC0, 64, 8'h23, 32'h300);
      base = src_idx;
      launch(32'hC0, 0);
      for (int k = 0; k < 500 && wr_cnt < 3; k++) @(negedge clk);
      enable = 1'b0;
      #1;
      chk("R7", "req/ready drop with enable", {30'd0, mem_req, src_ready}, 32'd0);
      w0 = wr_cnt;
      @(negedge clk);
      chk("R7", "busy after halt", 32'(busy), 32'd0);
      repeat (20) @(negedge clk);
      chk("R7", "no writes after halt", 32'(wr_cnt), 32'(w0));
      chk("R7", "word after halt point", mem[192 + w0], 32'hEEEE_0000 + 32'(192 + w0));
      for (int j = 0; j < w0; j++)
         chk("R3", "halted transfer word", mem[192 + j], 32'hA500_0000 + 32'(base + j));
      chk("R4", "no done after halt", 32'(done_cnt), 32'd0);

      // Row boundaries over a two-entry chain of 24 bytes (R9)
      for (int r = 0; r <= 24; r += 4) begin
         clr();
         desc(32'h100, 12, 8'h21, 32'h300);
         desc(32'h108, 12, 8'h23, 32'h340);
         launch(32'h100, r);
         wait_end();
         repeat (4) @(negedge clk);
         chk("R9", "row pulses", 32'(row_cnt), (r == 0) ? 32'd0 : 32'((24 / r)));
      end
      chk("R8", "read hold violations overall", 32'(hold_viol), 32'd0);

      summary();
      $finish;
   end
endmodule